// File: doc/BRIEF.md
# Standby Mode Controller

This block decides when a small microcontroller enters and leaves a deep standby state. In standby only the oscillator, the timebase counter and the watch counter keep running. Software asks for standby by writing a control byte whose request bit is 0. The controller accepts the request only when the clock system is running from the main oscillator or from the PLL, and only when no enabled interrupt is already waiting. Once it accepts, it turns off the CPU and peripheral clock enables. A select bit in the same byte decides whether the external pins float or keep their last levels.

An enabled interrupt wakes the device, and so does a synchronous external reset. An enabled interrupt is one whose 3-bit level is not all ones. On an interrupt wake, the clock enables return in the same cycle that the interrupt is sampled, and a one-cycle wake flag tells the CPU to resume. Reset also tells the clock system to go back to main-clock mode. Stored RAM and CPU register contents are never disturbed, because the block issues no reset of its own. All inputs are sampled on the free-running oscillator clock. While in standby, bus-hold requests are refused.

Top module: `stby_ctrl`

## Requirements
- R1: A write whose bit 0 is 0 starts standby from the next cycle, but only when `clk_mode` is 2'b00 (main) or 2'b01 (PLL) and no enabled interrupt is pending. When `clk_mode` is 2'b10 or 2'b11 the write does not start standby.
- R2: While `in_standby` is 1 and no wake is being taken, `cpu_clk_en` and `per_clk_en` are 0. At all other times they are 1.
- R3: The control byte reads back on `ctrl_rd`. Bit 0 is the request bit, bit 1 is the pin-float select, and bits 7:2 always read 0. Writes while running update bit 1.
- R4: A write of 0 to bit 0 does not start standby if `irq_pend` is 1 with a level other than 3'b111 in the same cycle. A pending interrupt at level 3'b111 does not block entry.
- R5: In standby with bit 1 = 1, `pin_hiz` is 1 and `pin_hold` is 0. In standby with bit 1 = 0, `pin_hold` is 1 and `pin_hiz` is 0. Outside standby both are 0.
- R6: Outside standby, `hold_ack` follows `hold_req` one cycle later. In the first cycle of standby, and in every cycle of it, `hold_ack` is 0.
- R7: In standby, a pending interrupt at any level other than 3'b111 causes a wake. A pending interrupt at level 3'b111 leaves the device in standby.
- R8: In the cycle a wake is sampled, `cpu_clk_en`, `per_clk_en` and `wake_pulse` are 1. In the next cycle `in_standby` is 0, `wake_pulse` is 0 and `ctrl_rd` bit 0 reads 1.
- R9: While `rst` is high, `force_main` is 1. The cycle after reset, the block is out of standby and `ctrl_rd` reads 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high external reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| clk_mode | input | 2 | Clock system status: 00 main, 01 PLL, 10 sub, 11 reserved |
| irq_pend | input | 1 | Interrupt request pending |
| irq_lvl | input | 3 | Level of the pending interrupt; 111 means disabled |
| hold_req | input | 1 | Bus-hold request |
| ctrl_rd | output | 8 | Control byte readback |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pin_hiz | output | 1 | External pins float |
| pin_hold | output | 1 | External pins keep their last levels |
| hold_ack | output | 1 | Bus-hold acknowledge |
| wake_pulse | output | 1 | One-cycle flag on leaving standby by interrupt |
| in_standby | output | 1 | Standby state |
| force_main | output | 1 | Tells the clock system to go to main-clock mode |

## Verification
The assertions check a set of properties on every cycle. They check that refused entries, caused by the wrong clock mode or a pending enabled interrupt, leave the state unchanged. They check that level-7 interrupts never end standby, that an enabled interrupt always does, and that the pins and the hold acknowledge stay quiet outside their allowed states. The wake flag must last a single cycle, and the request bit must read 1 whenever the block is running. Only the bench scenarios can show the exact readback values after specific byte writes, the effect of reset in the middle of standby, and the one-cycle lag of the hold acknowledge around entry and wake.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int CTRL_W   = 8;
    localparam int LVL_W    = 3;
    localparam int REQ_POS  = 0;
    localparam int PIN_POS  = 1;
    localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1);

    typedef enum logic [1:0] {
        CKM_MAIN = 2'b00,
        CKM_PLL  = 2'b01,
        CKM_SUB  = 2'b10,
        CKM_RSV  = 2'b11
    } clk_mode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STBY = 1'b1
    } stby_st_e;

    typedef struct packed {
        logic pin_float;
        logic run_req;
    } ctrl_t;

    function automatic logic irq_enabled(input logic pend, input logic [LVL_W-1:0] lvl);
        return pend && (lvl != {LVL_W{1'b1}});
    endfunction

    function automatic logic mode_allows(input clk_mode_e m);
        return (m == CKM_MAIN) || (m == CKM_PLL);
    endfunction

endpackage

// File: rtl/stby_seq.sv
module stby_seq
    import stby_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_req,
    input  clk_mode_e     clk_mode,
    input  logic          irq_pend,
    input  logic [LW-1:0] irq_lvl,
    output logic          in_stby,
    output logic          stby_nxt,
    output logic          enter,
    output logic          wake
);
    stby_st_e st_q, st_d;
    logic     irq_ok;

    assign irq_ok = irq_pend && (irq_lvl != {LW{1'b1}});

    always_comb begin
        enter = 1'b0;
        wake  = 1'b0;
        st_d  = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (wr_en && !wr_req && mode_allows(clk_mode) && !irq_ok) begin
                    enter = 1'b1;
                    st_d  = ST_STBY;
                end
            end
            ST_STBY: begin
                if (irq_ok) begin
                    wake = 1'b1;
                    st_d = ST_RUN;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    assign in_stby  = (st_q == ST_STBY);
    assign stby_nxt = (st_d == ST_STBY);

    AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!in_stby && wr_en && !wr_req && !mode_allows(clk_mode)) |=> !in_stby); // R1
    AST_IRQ_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!in_stby && wr_en && !wr_req && irq_enabled(irq_pend, irq_lvl)) |=> !in_stby); // R4
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (in_stby && irq_enabled(irq_pend, irq_lvl)) |=> !in_stby); // R7
    AST_LVL7_STAY: assert property (@(posedge clk) disable iff (rst)
        (in_stby && !irq_enabled(irq_pend, irq_lvl)) |=> in_stby); // R7
endmodule

// File: rtl/stby_regs.sv
module stby_regs
    import stby_pkg::*;
#(
    parameter int DW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_pin,
    input  logic          in_stby,
    input  logic          enter,
    input  logic          wake,
    output logic          pin_float,
    output logic [DW-1:0] rd
);
    ctrl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.run_req   <= 1'b1;
            ctl_q.pin_float <= 1'b0;
        end else begin
            if (wr_en && !in_stby) ctl_q.pin_float <= wr_pin;
            if (enter)             ctl_q.run_req   <= 1'b0;
            else if (wake)         ctl_q.run_req   <= 1'b1;
        end
    end

    always_comb begin
        rd          = '0;
        rd[REQ_POS] = ctl_q.run_req;
        rd[PIN_POS] = ctl_q.pin_float;
    end

    assign pin_float = ctl_q.pin_float;

    AST_REQ_RUN: assert property (@(posedge clk) disable iff (rst)
        !in_stby |-> rd[REQ_POS]); // R8
    AST_RST_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd == DW'(1))); // R9
endmodule

// File: rtl/stby_out.sv
module stby_out (
    input  logic clk,
    input  logic rst,
    input  logic in_stby,
    input  logic stby_nxt,
    input  logic wake,
    input  logic pin_float,
    input  logic hold_req,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic pin_hiz,
    output logic pin_hold,
    output logic hold_ack,
    output logic wake_pulse
);
    logic gate_on;
    logic ack_q;

    assign gate_on    = !in_stby || wake;
    assign cpu_clk_en = gate_on;
    assign per_clk_en = gate_on;
    assign wake_pulse = in_stby && wake;
    assign pin_hiz    = in_stby && pin_float;
    assign pin_hold   = in_stby && !pin_float;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= hold_req && !stby_nxt;
    end
    assign hold_ack = ack_q;

    AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (rst)
        in_stby |-> !hold_ack); // R6
    AST_WAKE_ONE: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse); // R8
    AST_PIN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pin_hiz && pin_hold)); // R5
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int DW = CTRL_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    clk_mode,
    input  logic          irq_pend,
    input  logic [LW-1:0] irq_lvl,
    input  logic          hold_req,
    output logic [DW-1:0] ctrl_rd,
    output logic          cpu_clk_en,
    output logic          per_clk_en,
    output logic          pin_hiz,
    output logic          pin_hold,
    output logic          hold_ack,
    output logic          wake_pulse,
    output logic          in_standby,
    output logic          force_main
);
    logic in_stby, stby_nxt, enter, wake, pin_float;
    logic unused_hi;

    assign unused_hi = ^wr_data[DW-1:PIN_POS+1];

    stby_seq #(.LW(LW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_req   (wr_data[REQ_POS]),
        .clk_mode (clk_mode_e'(clk_mode)),
        .irq_pend (irq_pend),
        .irq_lvl  (irq_lvl),
        .in_stby  (in_stby),
        .stby_nxt (stby_nxt),
        .enter    (enter),
        .wake     (wake)
    );

    stby_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_pin    (wr_data[PIN_POS]),
        .in_stby   (in_stby),
        .enter     (enter),
        .wake      (wake),
        .pin_float (pin_float),
        .rd        (ctrl_rd)
    );

    stby_out u_out (
        .clk        (clk),
        .rst        (rst),
        .in_stby    (in_stby),
        .stby_nxt   (stby_nxt),
        .wake       (wake),
        .pin_float  (pin_float),
        .hold_req   (hold_req),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .pin_hiz    (pin_hiz),
        .pin_hold   (pin_hold),
        .hold_ack   (hold_ack),
        .wake_pulse (wake_pulse)
    );

    assign in_standby = in_stby;
    assign force_main = rst;

    AST_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        (in_standby && !wake_pulse) |-> (!cpu_clk_en && !per_clk_en)); // R2
endmodule

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [1:0] clk_mode;
    logic       irq_pend;
    logic [2:0] irq_lvl;
    logic       hold_req;
    logic [7:0] ctrl_rd;
    logic cpu_clk_en, per_clk_en, pin_hiz, pin_hold, hold_ack, wake_pulse, in_standby, force_main;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    stby_ctrl i_stby_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .clk_mode(clk_mode),
        .irq_pend(irq_pend), .irq_lvl(irq_lvl), .hold_req(hold_req), .ctrl_rd(ctrl_rd),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pin_hiz(pin_hiz),
        .pin_hold(pin_hold), .hold_ack(hold_ack), .wake_pulse(wake_pulse),
        .in_standby(in_standby), .force_main(force_main)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        wr_en = 0; wr_data = 8'h00; irq_pend = 0; irq_lvl = 3'd7;
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic wake_up();
        irq_pend = 1; irq_lvl = 3'd1;
        step();
        irq_pend = 0; irq_lvl = 3'd7;
    endtask

    task automatic t_reset();
        rst = 1; idle(); clk_mode = 2'b00; hold_req = 0;
        step(); step();
        chk("R9", "force_main in reset", {7'd0, force_main}, 8'd1);
        rst = 0;
        step();
        chk("R9", "ctrl_rd after reset", ctrl_rd, 8'h01);
        chk("R3", "ctrl_rd default", ctrl_rd, 8'h01);
        chk("R2", "cpu_clk_en running", {7'd0, cpu_clk_en}, 8'd1);
        chk("R9", "not standby", {7'd0, in_standby}, 8'd0);
        chk("R5", "pins idle", {6'd0, pin_hiz, pin_hold}, 8'd0);
        chk("R9", "force_main released", {7'd0, force_main}, 8'd0);
    endtask

    task automatic t_enter_wake_main();
        clk_mode = 2'b00;
        write(8'h00);
        chk("R1", "entered from main", {7'd0, in_standby}, 8'd1);
        chk("R2", "gates off", {6'd0, cpu_clk_en, per_clk_en}, 8'd0);
        chk("R3", "readback in standby", ctrl_rd, 8'h00);
        chk("R5", "pins hold", {6'd0, pin_hiz, pin_hold}, 8'd1);
        irq_pend = 1; irq_lvl = 3'd7;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R7", "level 7 keeps standby", {7'd0, in_standby}, 8'd1);
        end
        irq_lvl = 3'd3;
        #1;
        chk("R8", "gates on at wake", {6'd0, cpu_clk_en, per_clk_en}, 8'h03);
        chk("R8", "wake_pulse", {7'd0, wake_pulse}, 8'd1);
        step();
        irq_pend = 0; irq_lvl = 3'd7;
        #1;
        chk("R7", "left standby", {7'd0, in_standby}, 8'd0);
        chk("R8", "wake_pulse one cycle", {7'd0, wake_pulse}, 8'd0);
        chk("R8", "request bit back", ctrl_rd, 8'h01);
        chk("R5", "pins released", {6'd0, pin_hiz, pin_hold}, 8'd0);
    endtask

    task automatic t_float_pll();
        clk_mode = 2'b01;
        write(8'h02);
        chk("R1", "entered from PLL", {7'd0, in_standby}, 8'd1);
        chk("R5", "pins float", {6'd0, pin_hiz, pin_hold}, 8'd2);
        chk("R3", "readback float", ctrl_rd, 8'h02);
        wake_up();
        chk("R8", "readback after wake", ctrl_rd, 8'h03);
        write(8'hFD);
        chk("R3", "upper bits ignored", ctrl_rd, 8'h01);
        chk("R3", "bit0 set no entry", {7'd0, in_standby}, 8'd0);
    endtask

    task automatic t_mode_block();
        clk_mode = 2'b10;
        write(8'h00);
        chk("R1", "sub mode no entry", {7'd0, in_standby}, 8'd0);
        clk_mode = 2'b11;
        write(8'h00);
        chk("R1", "reserved mode no entry", {7'd0, in_standby}, 8'd0);
        chk("R1", "readback unchanged", ctrl_rd, 8'h01);
        clk_mode = 2'b00;
    endtask

    task automatic t_irq_block();
        irq_pend = 1; irq_lvl = 3'd2;
        write(8'h00);
        chk("R4", "pending irq blocks", {7'd0, in_standby}, 8'd0);
        chk("R4", "gates stay on", {7'd0, cpu_clk_en}, 8'd1);
        irq_lvl = 3'd7;
        write(8'h00);
        chk("R4", "level 7 does not block", {7'd0, in_standby}, 8'd1);
        irq_pend = 0;
        wake_up();
        chk("R7", "woke", {7'd0, in_standby}, 8'd0);
    endtask

    task automatic t_hold();
        hold_req = 1;
        step();
        chk("R6", "hold ack running", {7'd0, hold_ack}, 8'd1);
        write(8'h00);
        chk("R6", "hold ack off on entry", {7'd0, hold_ack}, 8'd0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R6", "hold ack off in standby", {7'd0, hold_ack}, 8'd0);
        end
        wake_up();
        chk("R6", "hold ack after wake", {7'd0, hold_ack}, 8'd1);
        hold_req = 0;
        step();
        chk("R6", "hold ack follows release", {7'd0, hold_ack}, 8'd0);
    endtask

    task automatic t_reset_in_standby();
        write(8'h02);
        chk("R1", "standby before reset", {7'd0, in_standby}, 8'd1);
        rst = 1;
        #1;
        chk("R9", "force_main", {7'd0, force_main}, 8'd1);
        step();
        rst = 0;
        step();
        chk("R9", "reset exits standby", {7'd0, in_standby}, 8'd0);
        chk("R9", "reset defaults", ctrl_rd, 8'h01);
        chk("R2", "gates on after reset", {6'd0, cpu_clk_en, per_clk_en}, 8'h03);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    failures++;
                    $display("FAIL watchdog actual=timeout expected=done");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none
        t_reset();
        t_enter_wake_main();
        t_float_pll();
        t_mode_block();
        t_irq_block();
        t_hold();
        t_reset_in_standby();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule